// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master end of a two-wire PHY management link. A host presents a single request: a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then produces the complete serial frame on its own. It generates the management clock from the system clock through a programmable divider. It drives or releases the data pad through separate output-value, output-enable and input-value pins. When the frame is over it pulses `done` and returns read data together with an error flag.

Every frame opens with a long run of ones, even where a PHY would accept a shortened preamble. On reads the block checks the turnaround bit that the PHY is expected to pull low. A PHY that fails to answer is treated as a link error. The block then clocks a long released recovery run so that the PHY's serial state machine is resynchronised, and reports the failure through `err` instead of returning data.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc`, `mdio_oe`, `busy`, `done` and `err` are 0 and `rdata` is 0x0000.
- R2: Each frame begins with 32 MDC rising edges during which `mdio_oe`=1 and `mdio_o`=1.
- R3: The next 14 bits, one per MDC rising edge and all driven, are: 0, 1, then the opcode (1,0 for a read where `req_rd`=1, 0,1 for a write), then `req_phy` from bit 4 down to bit 0, then `req_reg` from bit 4 down to bit 0.
- R4: A write then drives the turnaround pair 1,0, then `req_wdata` from bit 15 down to bit 0, then releases the pad (`mdio_oe`=0) for one more MDC cycle. That is 65 MDC rising edges in total, after which `done` pulses with `err`=0.
- R5: A read releases the pad from the turnaround onward. It takes the second turnaround bit and then 16 data bits, MSB first, from the synchronised `mdio_i` on the system clock at which MDC rises, so the PHY must hold each bit for at least 3 system clocks before that edge. Two released tail cycles follow, for 66 MDC rising edges, and then `done` pulses with `err`=0 and `rdata` set to the sampled word.
- R6: If the second turnaround bit of a read is 1, the block clocks 32 further MDC cycles with the pad released, for 80 rising edges in all, and then pulses `done` with `err`=1 and `rdata`=0x0000.
- R7: `mdio_o` and `mdio_oe` change only on the system clock at which MDC falls, so they are stable across every MDC rising edge.
- R8: Each MDC half-period lasts max(`cfg_half`, 3) system clocks, using the value captured when the request is accepted. MDC is low whenever the block is idle.
- R9: `busy` rises on the clock after a request is accepted and falls on the clock where `done` pulses for one cycle. A request made while `busy` is 1 is ignored and does not alter the running frame.
- R10: A request presented in the same cycle as the `done` pulse is accepted and starts a new frame on the next clock.
- R11: `rdata` and `err` keep their values until the next `done`. A completed write leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, taken when idle |
| req_rd | input | 1 | 1 = read frame, 0 = write frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Value to write |
| cfg_half | input | DIV_W (8) | MDC half-period in system clocks |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Last frame ended with a bad turnaround |
| rdata | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Pad output value |
| mdio_oe | output | 1 | Pad output enable |
| mdio_i | input | 1 | Pad input value (asynchronous) |

## Verification
The end of one frame and the acceptance of the next can fall in the same cycle. The `done` pulse and the idle check that admits a new request share that cycle. The bench raises `req` with fresh parameters on exactly the cycle where it sees `done`. It judges the result by requiring `busy` one clock later and by decoding the pad bits of the following frame against the new request, not the old one. The opposite case is a request landing mid-frame. The bench judges that one by checking that the running frame decodes unchanged and that no second frame follows.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int HDR_BITS = 4 + 2 * ADDR_W;
  localparam int TA_BITS  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_TA,
    ST_DATA,
    ST_TAIL,
    ST_RECOV
  } mgmt_state_e;

  // start pattern, opcode, PHY address, register address
  function automatic logic [HDR_BITS-1:0] build_header(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg
  );
    logic [1:0] op;
    op = rd ? 2'b10 : 2'b01;
    return {2'b01, op, phy, rg};
  endfunction

  // half-period floor so the input synchroniser settles before sampling
  function automatic logic [15:0] clamp_half(
    input logic [15:0] h,
    input logic [15:0] lo
  );
    return (h < lo) ? lo : h;
  endfunction

  // bit count of each frame phase
  function automatic int phase_len(
    input mgmt_state_e st,
    input logic        rd,
    input int          pre_len,
    input int          recov_len,
    input int          rd_tail,
    input int          wr_tail
  );
    case (st)
      ST_PRE:   return pre_len;
      ST_HDR:   return HDR_BITS;
      ST_TA:    return TA_BITS;
      ST_DATA:  return DATA_W;
      ST_TAIL:  return rd ? rd_tail : wr_tail;
      ST_RECOV: return recov_len;
      default:  return 1;
    endcase
  endfunction

endpackage

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= 1'b1;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] half_in,
  input  logic             run,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic             mdc
);
  import mdio_mgmt_pkg::*;

  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_HALF);

  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             term;

  assign term     = (cnt_q == half_q - DIV_W'(1));
  assign rise_evt = run && term && !mdc_q;
  assign fall_evt = run && term && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= MIN_V;
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
    end else begin
      if (load) half_q <= DIV_W'(clamp_half(16'(half_in), 16'(MIN_HALF)));
      if (!run) begin
        cnt_q <= '0;
        mdc_q <= 1'b0;
      end else if (term) begin
        cnt_q <= '0;
        mdc_q <= ~mdc_q;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assert_rise_lifts_mdc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> mdc_q);
  assert_fall_drops_mdc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !mdc_q);
  assert_idle_mdc_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc_q);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
  parameter int PRE_LEN   = 32,
  parameter int RECOV_LEN = 32,
  parameter int RD_TAIL   = 2,
  parameter int WR_TAIL   = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        req_rd,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdi_s,
  output logic        accept,
  output logic        run,
  output logic        mdo,
  output logic        mdo_en,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] rdata
);
  import mdio_mgmt_pkg::*;

  localparam int MAXC = (PRE_LEN > RECOV_LEN) ?
                        ((PRE_LEN > DATA_W) ? PRE_LEN : DATA_W) :
                        ((RECOV_LEN > DATA_W) ? RECOV_LEN : DATA_W);
  localparam int CW   = $clog2(MAXC + 1);

  mgmt_state_e         state_q;
  logic [CW-1:0]       cnt_q;
  logic                rd_q;
  logic [HDR_BITS-1:0] hdr_q;
  logic [DATA_W-1:0]   wsh_q;
  logic [DATA_W-1:0]   rsh_q;
  logic                ta_bad_q;
  logic                done_q;
  logic                err_q;
  logic [DATA_W-1:0]   rdata_q;

  logic [CW-1:0] limit_m1;
  logic          last_bit;
  logic          ta_sample;
  logic          data_sample;
  logic          recov_end;

  assign limit_m1    = CW'(phase_len(state_q, rd_q, PRE_LEN, RECOV_LEN, RD_TAIL, WR_TAIL) - 1);
  assign last_bit    = fall_evt && (cnt_q == limit_m1);
  assign ta_sample   = rise_evt && rd_q && (state_q == ST_TA) && (cnt_q == CW'(1));
  assign data_sample = rise_evt && rd_q && (state_q == ST_DATA);
  assign recov_end   = last_bit && (state_q == ST_RECOV);

  assign accept = req && (state_q == ST_IDLE);
  assign busy   = (state_q != ST_IDLE);
  assign run    = busy;
  assign done   = done_q;
  assign err    = err_q;
  assign rdata  = rdata_q;

  // pad drive for the bit in flight
  always_comb begin
    mdo_en = 1'b0;
    mdo    = 1'b0;
    case (state_q)
      ST_PRE: begin
        mdo_en = 1'b1;
        mdo    = 1'b1;
      end
      ST_HDR: begin
        mdo_en = 1'b1;
        mdo    = hdr_q[HDR_BITS-1];
      end
      ST_TA: begin
        mdo_en = !rd_q;
        mdo    = !rd_q && (cnt_q == '0);
      end
      ST_DATA: begin
        mdo_en = !rd_q;
        mdo    = !rd_q && wsh_q[DATA_W-1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rd_q     <= 1'b0;
      hdr_q    <= '0;
      wsh_q    <= '0;
      rsh_q    <= '0;
      ta_bad_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q  <= ST_PRE;
        cnt_q    <= '0;
        rd_q     <= req_rd;
        hdr_q    <= build_header(req_rd, req_phy, req_reg);
        wsh_q    <= req_wdata;
        ta_bad_q <= 1'b0;
      end else if (busy) begin
        if (ta_sample)   ta_bad_q <= mdi_s;
        if (data_sample) rsh_q    <= {rsh_q[DATA_W-2:0], mdi_s};
        if (last_bit) begin
          cnt_q <= '0;
          case (state_q)
            ST_PRE:  state_q <= ST_HDR;
            ST_HDR:  state_q <= ST_TA;
            ST_TA:   state_q <= (rd_q && ta_bad_q) ? ST_RECOV : ST_DATA;
            ST_DATA: state_q <= ST_TAIL;
            ST_TAIL: begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              err_q   <= 1'b0;
              if (rd_q) rdata_q <= rsh_q;
            end
            ST_RECOV: begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              rdata_q <= '0;
            end
            default: state_q <= ST_IDLE;
          endcase
        end else if (fall_evt) begin
          cnt_q <= cnt_q + CW'(1);
          if (state_q == ST_HDR)            hdr_q <= hdr_q << 1;
          if (state_q == ST_DATA && !rd_q)  wsh_q <= wsh_q << 1;
        end
      end
    end
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);
  assert_busy_req_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && busy) |=> $stable(rd_q));
  assert_frame_opens_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mdo_en && mdo));
  assert_recovery_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    recov_end |=> (done_q && err_q && rdata_q == '0));
  assert_read_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ta_sample || data_sample) |-> !mdo_en);
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W     = 8,
  parameter int MIN_HALF  = 3,
  parameter int SYNC_LEN  = 2,
  parameter int PRE_LEN   = 32,
  parameter int RECOV_LEN = 32,
  parameter int RD_TAIL   = 2,
  parameter int WR_TAIL   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_rd,
  input  logic [4:0]       req_phy,
  input  logic [4:0]       req_reg,
  input  logic [15:0]      req_wdata,
  input  logic [DIV_W-1:0] cfg_half,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [15:0]      rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic accept;
  logic run;
  logic rise_evt;
  logic fall_evt;
  logic mdi_s;

  mdio_in_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mdio_i),
    .q     (mdi_s)
  );

  mdc_divider #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .half_in  (cfg_half),
    .run      (run),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdc      (mdc)
  );

  mdio_frame_seq #(
    .PRE_LEN   (PRE_LEN),
    .RECOV_LEN (RECOV_LEN),
    .RD_TAIL   (RD_TAIL),
    .WR_TAIL   (WR_TAIL)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_rd    (req_rd),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .mdi_s     (mdi_s),
    .accept    (accept),
    .run       (run),
    .mdo       (mdio_o),
    .mdo_en    (mdio_oe),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .rdata     (rdata)
  );

  assert_pad_stable_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  assert_accept_starts_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_rd = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  cfg_half = 8'd3;
  logic        busy, done, err, mdc, mdio_o, mdio_oe;
  logic [15:0] rdata;
  logic        mdio_i;

  int n_chk = 0;
  int n_bad = 0;

  // PHY model parameters of the frame in flight
  logic        m_rd = 1'b0;
  logic        m_ta = 1'b1;
  logic [15:0] m_data = '0;

  // pad monitor
  int   rcnt = 0;
  logic mdc_q = 1'b0;
  int   hi_run = 0;
  int   last_hi = 0;
  int   clash = 0;
  logic seen_en [0:127];
  logic seen_v  [0:127];

  logic phy_en;
  logic phy_val;

  always #5 clk = ~clk;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .cfg_half(cfg_half),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign phy_en  = m_rd && m_ta && (rcnt >= 47) && (rcnt <= 63);
  assign phy_val = (rcnt == 47) ? 1'b0 : m_data[15 - ((rcnt - 48) & 15)];
  assign mdio_i  = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  always @(posedge clk) begin
    mdc_q <= mdc;
    if (mdio_oe && phy_en) clash <= clash + 1;
    if (mdc) hi_run <= hi_run + 1;
    else if (mdc_q) begin
      last_hi <= hi_run;
      hi_run  <= 0;
    end
    if (req && !busy) rcnt <= 0;
    else if (mdc && !mdc_q) begin
      if (rcnt < 128) begin
        seen_en[rcnt] <= mdio_oe;
        seen_v[rcnt]  <= mdio_o;
      end
      rcnt <= rcnt + 1;
    end
  end

  task automatic check(input string req_tag, input logic ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // expected pad state {enable, value} of bit k
  function automatic logic [1:0] exp_pin(input int k, input logic rd, input logic [4:0] p,
                                         input logic [4:0] r, input logic [15:0] d);
    if (k < 32) return 2'b11;
    if (k == 32) return 2'b10;
    if (k == 33) return 2'b11;
    if (k == 34) return {1'b1, rd};
    if (k == 35) return {1'b1, ~rd};
    if (k < 41) return {1'b1, p[40 - k]};
    if (k < 46) return {1'b1, r[45 - k]};
    if (rd) return 2'b00;
    if (k == 46) return 2'b11;
    if (k == 47) return 2'b10;
    if (k < 64) return {1'b1, d[63 - k]};
    return 2'b00;
  endfunction

  task automatic launch(input logic rd, input logic ta, input logic [4:0] p,
                        input logic [4:0] r, input logic [15:0] d, input logic [7:0] h);
    req_rd = rd; req_phy = p; req_reg = r; req_wdata = d; cfg_half = h;
    m_rd = rd; m_ta = ta; m_data = d;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check("R9 busy after accept", busy == 1'b1, busy, 1);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check("R9 done reached (watchdog)", done == 1'b1, done, 1);
  endtask

  logic [15:0] prev_rdata = 16'h0000;

  task automatic judge(input logic rd, input logic ta, input logic [4:0] p,
                       input logic [4:0] r, input logic [15:0] d, input logic [7:0] h);
    int exp_r;
    int bad_k = -1;
    logic [15:0] exp_d;
    exp_r = rd ? (ta ? 66 : 80) : 65;
    exp_d = rd ? (ta ? d : 16'h0000) : prev_rdata;
    check(rd ? (ta ? "R5 rise count" : "R6 rise count") : "R4 rise count", rcnt == exp_r, rcnt, exp_r);
    for (int k = 0; k < exp_r; k++) begin
      logic [1:0] e;
      e = exp_pin(k, rd, p, r, d);
      if (seen_en[k] !== e[1] || (e[1] && seen_v[k] !== e[0])) begin
        if (bad_k < 0) bad_k = k;
      end
    end
    check("R2 R3 R4 R5 pad bits", bad_k < 0, bad_k, -1);
    check(rd ? "R6 err flag" : "R4 err flag", err == (rd && !ta), err, rd && !ta);
    check(rd ? "R5 R6 rdata" : "R11 rdata kept", rdata == exp_d, rdata, exp_d);
    check("R8 half period", last_hi == ((h < 3) ? 3 : int'(h)), last_hi, (h < 3) ? 3 : h);
    prev_rdata = exp_d;
  endtask

  // {rd, ta_ok, phy, reg, data, half}
  localparam int NV = 7;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 1'b1, 5'h01, 5'h00, 16'hA55A, 8'd3},
    {1'b1, 1'b1, 5'h1F, 5'h1F, 16'hC3E1, 8'd4},
    {1'b0, 1'b1, 5'h10, 5'h11, 16'hFFFF, 8'd5},
    {1'b1, 1'b1, 5'h00, 5'h01, 16'h0001, 8'd3},
    {1'b1, 1'b0, 5'h05, 5'h0A, 16'h1234, 8'd3},
    {1'b1, 1'b1, 5'h15, 5'h0A, 16'h8000, 8'd6},
    {1'b0, 1'b1, 5'h0A, 5'h15, 16'h0000, 8'd1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mdc", mdc == 1'b0, mdc, 0);
    check("R1 oe", mdio_oe == 1'b0, mdio_oe, 0);
    check("R1 busy/done/err", {busy, done, err} == 3'b000, {busy, done, err}, 0);
    check("R1 rdata", rdata == 16'h0000, rdata, 0);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      launch(v[35], v[34], v[33:29], v[28:24], v[23:8], v[7:0]);
      wait_done();
      judge(v[35], v[34], v[33:29], v[28:24], v[23:8], v[7:0]);
      @(negedge clk);
      check("R11 done single pulse", done == 1'b0, done, 0);
      check("R11 err held", err == (v[35] && !v[34]), err, v[35] && !v[34]);
      repeat (3) @(negedge clk);
    end

    // R9: request during a running frame is ignored
    launch(1'b0, 1'b1, 5'h03, 5'h0C, 16'h5A0F, 8'd3);
    repeat (40) @(negedge clk);
    req_rd = 1'b1; req_phy = 5'h1C; req_reg = 5'h03; req_wdata = 16'hFFFF;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_done();
    judge(1'b0, 1'b1, 5'h03, 5'h0C, 16'h5A0F, 8'd3);
    begin
      int busy_seen = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (busy) busy_seen++;
      end
      check("R9 no extra frame", busy_seen == 0, busy_seen, 0);
    end

    // R10: request in the done cycle starts the next frame
    launch(1'b1, 1'b1, 5'h12, 5'h07, 16'h6C39, 8'd3);
    wait_done();
    judge(1'b1, 1'b1, 5'h12, 5'h07, 16'h6C39, 8'd3);
    launch(1'b0, 1'b1, 5'h0F, 5'h10, 16'h3C3C, 8'd4);
    wait_done();
    judge(1'b0, 1'b1, 5'h0F, 5'h10, 16'h3C3C, 8'd4);
    check("R10 R11 read result kept after write", rdata == 16'h6C39, rdata, 16'h6C39);

    @(negedge clk);
    check("R8 mdc low when idle", mdc == 1'b0, mdc, 0);
    check("R5 no pad contention", clash == 0, clash, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule